// File: doc/BRIEF.md
# Serial Interrupt Host Start and Capture Engine

This block is the host end of a shared, open-drain serial interrupt wire that runs on the bus clock. It opens every interrupt cycle with a start frame and then walks a fixed train of three-clock slots, one slot per interrupt source. In the first clock of each slot it samples the wire to rebuild a parallel interrupt vector. It closes the cycle with a stop frame, and the length of that stop frame tells the peripherals which start mode comes next.

In continuous mode the host starts cycles on its own, a fixed idle gap after each stop frame. In quiet mode the host stays idle until a peripheral pulls the wire low for one clock. It then takes over on the very next clock and completes the start frame. The start low time is set by a 3-bit width input. The host never drives the wire during the slots. It drives low only in the start and stop frames, and drives high for exactly one clock after each of those low periods.

States: `ST_GAP` (continuous idle countdown), `ST_IDLE` (quiet mode, waiting for a peripheral pulse), `ST_START_LOW`, `ST_START_HIGH`, `ST_SLOTS`, `ST_STOP_LOW` and `ST_STOP_HIGH`. The transitions are:
- reset → `ST_GAP`
- `ST_GAP` → `ST_START_LOW` when the gap count expires
- `ST_IDLE` → `ST_START_LOW` when the wire is sampled low
- `ST_START_LOW` → `ST_START_HIGH` when the low count expires
- `ST_START_HIGH` → `ST_SLOTS`
- `ST_SLOTS` → `ST_STOP_LOW` after the last clock of the last slot
- `ST_STOP_LOW` → `ST_STOP_HIGH` when the stop count expires
- `ST_STOP_HIGH` → `ST_IDLE` if quiet mode was selected, otherwise → `ST_GAP`

Top module: `sirq_host`

## Requirements
- R1: While reset is held and just after it is released, `drive_low`, `drive_high`, `irq_vec` and `quiet_mode` are all 0. The first start frame begins after `IDLE_GAP` clocks (default 4) in `ST_GAP`.
- R2: In continuous mode the start frame drives the wire low for 4 + `start_width` clocks when `start_width` is 0 to 4. No low period of the host ever exceeds 8 clocks.
- R3: In quiet mode, a low level sampled on `line_in` while the host is idle makes the host assert `drive_low` from the next clock on, for (start length − 1) clocks. The total low time is then equal to the continuous start length.
- R4: When any low period of the host ends, `drive_high` is 1 for exactly one clock. After that clock both drives are 0.
- R5: After the start frame come `NUM_SLOTS` (default 16) slots of 3 clocks each, and the host drives nothing during them.
- R6: In the first clock of slot k, a low level on `line_in` sets `irq_vec[k]` to 1 and a high level sets it to 0. The new value is visible from the next clock.
- R7: After the last slot, the stop frame drives low for 2 clocks if `quiet_req` is 1 in the last slot clock, or for 3 clocks if it is 0, followed by one high clock.
- R8: After a stop frame that selected quiet mode, `quiet_mode` is 1 and the host starts no cycle on its own. After one that selected continuous mode, `quiet_mode` is 0 and the next start frame begins after `IDLE_GAP` idle clocks.
- R9: `start_width` values 5, 6 and 7 give a start low time of 8 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Level sampled from the shared wire (0 = low) |
| quiet_req | input | 1 | Select quiet mode for the next cycle (sampled in the last slot clock) |
| start_width | input | WIDTH_BITS | Start low-time selector, 4 + min(value, 4) clocks |
| drive_low | output | 1 | Drive the wire low this clock |
| drive_high | output | 1 | Drive the wire high this clock |
| irq_vec | output | NUM_SLOTS | Rebuilt interrupt vector, bit k = slot k active |
| quiet_mode | output | 1 | 1 while quiet mode is in effect |

## Verification
Most wrong internal states show up on the drive pins within one frame. A count that is off by one lengthens or shortens a start or stop low period, or moves the one-clock high pulse. A slot sequencer that is out of step writes the sampled level into the wrong bit of `irq_vec`, and that is visible as soon as the cycle's slots are done. A wrong mode register shows up right after the stop frame: the host either starts a cycle without a peripheral pulse, or waits for one that never comes. The bench therefore walks every start width in both modes, with interrupt patterns that differ from cycle to cycle. It checks the drive pins on every clock.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
    typedef enum logic [2:0] {
        ST_GAP,
        ST_IDLE,
        ST_START_LOW,
        ST_START_HIGH,
        ST_SLOTS,
        ST_STOP_LOW,
        ST_STOP_HIGH
    } state_e;
endpackage

// File: rtl/sirq_start_len.sv
// Turns the width selector into a start low length, clamped at the top.
module sirq_start_len #(
    parameter int WIDTH_BITS = 3,
    parameter int BASE_LEN   = 4,
    parameter int MAX_EXTRA  = 4,
    parameter int LEN_W      = 4
) (
    input  logic [WIDTH_BITS-1:0] width_sel,
    output logic [LEN_W-1:0]      low_len
);
    logic [LEN_W-1:0] extra;

    always_comb begin
        if (int'(width_sel) > MAX_EXTRA)
            extra = LEN_W'(MAX_EXTRA);
        else
            extra = LEN_W'(width_sel);
        low_len = LEN_W'(BASE_LEN) + extra;
    end
endmodule

// File: rtl/sirq_slot_seq.sv
// Steps through the slot train: slot index and phase inside the slot.
module sirq_slot_seq #(
    parameter int NUM_SLOTS = 16,
    parameter int SLOT_CLKS = 3,
    localparam int IDX_W    = $clog2(NUM_SLOTS),
    localparam int PH_W     = $clog2(SLOT_CLKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    output logic [IDX_W-1:0] slot_idx,
    output logic             sample_en,
    output logic             last_clk
);
    logic [PH_W-1:0]  ph_q;
    logic [IDX_W-1:0] idx_q;
    logic             ph_end;

    assign ph_end    = (ph_q == PH_W'(SLOT_CLKS - 1));
    assign slot_idx  = idx_q;
    assign sample_en = run && (ph_q == '0);
    assign last_clk  = run && ph_end && (idx_q == IDX_W'(NUM_SLOTS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q  <= '0;
            idx_q <= '0;
        end else if (!run) begin
            ph_q  <= '0;
            idx_q <= '0;
        end else if (ph_end) begin
            ph_q  <= '0;
            idx_q <= idx_q + IDX_W'(1);
        end else begin
            ph_q  <= ph_q + PH_W'(1);
        end
    end
endmodule

// File: rtl/sirq_vec_capture.sv
// One flop per slot: loaded with the inverted wire level in its sample clock.
module sirq_vec_capture #(
    parameter int NUM_SLOTS = 16,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_en,
    input  logic [IDX_W-1:0]     slot_idx,
    input  logic                 line_in,
    output logic [NUM_SLOTS-1:0] irq_vec
);
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                irq_vec[i] <= 1'b0;
            else if (sample_en && (slot_idx == IDX_W'(i)))
                irq_vec[i] <= !line_in;
        end
    end
endmodule

// File: rtl/sirq_host.sv
module sirq_host #(
    parameter int NUM_SLOTS  = 16,
    parameter int IDLE_GAP   = 4,
    parameter int WIDTH_BITS = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  line_in,
    input  logic                  quiet_req,
    input  logic [WIDTH_BITS-1:0] start_width,
    output logic                  drive_low,
    output logic                  drive_high,
    output logic [NUM_SLOTS-1:0]  irq_vec,
    output logic                  quiet_mode
);
    import sirq_pkg::*;

    localparam int SLOT_CLKS = 3;
    localparam int LEN_W     = 4;
    localparam int MAX_CNT   = (IDLE_GAP > 8) ? IDLE_GAP : 8;
    localparam int CNT_W     = $clog2(MAX_CNT + 1);
    localparam int IDX_W     = $clog2(NUM_SLOTS);

    state_e           state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             quiet_q, quiet_d;
    logic             stop_quiet_q, stop_quiet_d;
    logic [LEN_W-1:0] low_len;
    logic [IDX_W-1:0] slot_idx;
    logic             sample_en;
    logic             slot_last;
    logic             slots_run;
    logic             cnt_done;

    sirq_start_len #(
        .WIDTH_BITS (WIDTH_BITS),
        .BASE_LEN   (4),
        .MAX_EXTRA  (4),
        .LEN_W      (LEN_W)
    ) len_i (
        .width_sel (start_width),
        .low_len   (low_len)
    );

    assign slots_run = (state_q == ST_SLOTS);

    sirq_slot_seq #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_CLKS (SLOT_CLKS)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (slots_run),
        .slot_idx  (slot_idx),
        .sample_en (sample_en),
        .last_clk  (slot_last)
    );

    sirq_vec_capture #(
        .NUM_SLOTS (NUM_SLOTS)
    ) cap_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .slot_idx  (slot_idx),
        .line_in   (line_in),
        .irq_vec   (irq_vec)
    );

    assign cnt_done = (cnt_q == '0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_GAP;
            cnt_q        <= CNT_W'(IDLE_GAP - 1);
            quiet_q      <= 1'b0;
            stop_quiet_q <= 1'b0;
        end else begin
            state_q      <= state_d;
            cnt_q        <= cnt_d;
            quiet_q      <= quiet_d;
            stop_quiet_q <= stop_quiet_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d      = state_q;
        cnt_d        = cnt_q;
        quiet_d      = quiet_q;
        stop_quiet_d = stop_quiet_q;
        unique case (state_q)
            ST_GAP: begin
                if (cnt_done) begin
                    state_d = ST_START_LOW;
                    cnt_d   = CNT_W'(low_len) - CNT_W'(1);
                end else begin
                    cnt_d   = cnt_q - CNT_W'(1);
                end
            end
            ST_IDLE: begin
                if (!line_in) begin
                    state_d = ST_START_LOW;
                    cnt_d   = CNT_W'(low_len) - CNT_W'(2);
                end
            end
            ST_START_LOW: begin
                if (cnt_done)
                    state_d = ST_START_HIGH;
                else
                    cnt_d   = cnt_q - CNT_W'(1);
            end
            ST_START_HIGH: begin
                state_d = ST_SLOTS;
            end
            ST_SLOTS: begin
                if (slot_last) begin
                    state_d      = ST_STOP_LOW;
                    stop_quiet_d = quiet_req;
                    cnt_d        = quiet_req ? CNT_W'(1) : CNT_W'(2);
                end
            end
            ST_STOP_LOW: begin
                if (cnt_done)
                    state_d = ST_STOP_HIGH;
                else
                    cnt_d   = cnt_q - CNT_W'(1);
            end
            ST_STOP_HIGH: begin
                quiet_d = stop_quiet_q;
                if (stop_quiet_q) begin
                    state_d = ST_IDLE;
                end else begin
                    state_d = ST_GAP;
                    cnt_d   = CNT_W'(IDLE_GAP - 1);
                end
            end
            default: begin
                state_d = ST_GAP;
                cnt_d   = CNT_W'(IDLE_GAP - 1);
            end
        endcase
    end

    // Outputs
    always_comb begin
        drive_low  = (state_q == ST_START_LOW) || (state_q == ST_STOP_LOW);
        drive_high = (state_q == ST_START_HIGH) || (state_q == ST_STOP_HIGH);
        quiet_mode = quiet_q;
    end
endmodule

// File: rtl/sirq_host_chk.sv
module sirq_host_chk #(
    parameter int NUM_SLOTS = 16,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 line_in,
    input logic                 drive_low,
    input logic                 drive_high,
    input logic                 quiet_mode,
    input logic [NUM_SLOTS-1:0] irq_vec,
    input sirq_pkg::state_e     state_q,
    input logic                 sample_en,
    input logic [IDX_W-1:0]     slot_idx
);
    logic [3:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            low_run <= '0;
        else if (drive_low)
            low_run <= (low_run == 4'd15) ? low_run : low_run + 4'd1;
        else
            low_run <= '0;
    end

    // R2: a low period of the host never exceeds 8 clocks
    assert_low_len_max_R2: assert property (@(posedge clk) disable iff (!rst_n)
        drive_low |-> (low_run < 4'd8));

    // R4: every low period ends in a high clock
    assert_high_after_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drive_low) |-> drive_high);

    // R4: the high clock lasts one clock and is followed by release
    assert_high_one_clk_R4: assert property (@(posedge clk) disable iff (!rst_n)
        drive_high |=> (!drive_high && !drive_low));

    // R3: a low level seen while idle in quiet mode is taken over next clock
    assert_quiet_takeover_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet_mode && state_q == sirq_pkg::ST_IDLE && !line_in) |=> drive_low);

    // R8: in quiet mode the host does not start while the wire stays high
    assert_quiet_no_auto_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == sirq_pkg::ST_IDLE && line_in) |=> !drive_low);

    // R6: the sampled slot bit follows the inverted wire level
    assert_slot_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |=> (irq_vec[$past(slot_idx)] == !$past(line_in)));

    // R5: no drive while slots run
    assert_slots_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == sirq_pkg::ST_SLOTS) |-> (!drive_low && !drive_high));
endmodule

bind sirq_host sirq_host_chk #(.NUM_SLOTS(NUM_SLOTS)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_in    (line_in),
    .drive_low  (drive_low),
    .drive_high (drive_high),
    .quiet_mode (quiet_mode),
    .irq_vec    (irq_vec),
    .state_q    (state_q),
    .sample_en  (sample_en),
    .slot_idx   (slot_idx)
);

// File: tb/sirq_host_tb.sv
module sirq_host_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NSLOT      = 16;
    localparam int GAP        = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             periph_low = 1'b0;
    logic             quiet_req = 1'b0;
    logic [2:0]       start_width = 3'd0;
    logic             drive_low, drive_high, quiet_mode;
    logic [NSLOT-1:0] irq_vec;
    logic             line_in;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    assign line_in = !(drive_low || periph_low);

    always #(CLK_PERIOD / 2) clk = ~clk;

    sirq_host #(.NUM_SLOTS(NSLOT), .IDLE_GAP(GAP), .WIDTH_BITS(3)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_in     (line_in),
        .quiet_req   (quiet_req),
        .start_width (start_width),
        .drive_low   (drive_low),
        .drive_high  (drive_high),
        .irq_vec     (irq_vec),
        .quiet_mode  (quiet_mode)
    );

    task automatic check_eq(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Checks {drive_low, drive_high} for n clocks, one check per negedge.
    task automatic expect_run(int n, bit lo, bit hi, string req);
        for (int i = 0; i < n; i++) begin
            check_eq(req, int'({drive_low, drive_high}), int'({lo, hi}));
            @(negedge clk);
        end
    endtask

    function automatic int start_len(int w);
        return 4 + ((w > 4) ? 4 : w);
    endfunction

    task automatic run_tail(logic [NSLOT-1:0] pat, bit q);
        expect_run(1, 1'b0, 1'b1, "R4");
        for (int k = 0; k < NSLOT; k++) begin
            periph_low = pat[k];
            expect_run(1, 1'b0, 1'b0, "R5");
            periph_low = 1'b0;
            expect_run(2, 1'b0, 1'b0, "R5");
        end
        check_eq("R6", int'(irq_vec), int'(pat));
        expect_run(q ? 2 : 3, 1'b1, 1'b0, "R7");
        expect_run(1, 1'b0, 1'b1, "R7");
        check_eq("R8", int'(quiet_mode), int'(q));
    endtask

    task automatic cont_cycle(int w, bit q, logic [NSLOT-1:0] pat);
        start_width = 3'(w);
        quiet_req   = q;
        expect_run(GAP, 1'b0, 1'b0, "R8");
        expect_run(start_len(w), 1'b1, 1'b0, (w > 4) ? "R9" : "R2");
        run_tail(pat, q);
    endtask

    task automatic quiet_cycle(int w, bit q, logic [NSLOT-1:0] pat);
        start_width = 3'(w);
        quiet_req   = q;
        expect_run(6, 1'b0, 1'b0, "R8");
        periph_low = 1'b1;
        expect_run(1, 1'b0, 1'b0, "R3");
        periph_low = 1'b0;
        expect_run(start_len(w) - 1, 1'b1, 1'b0, (w > 4) ? "R9" : "R3");
        run_tail(pat, q);
    endtask

    function automatic logic [NSLOT-1:0] pattern(int w, int salt);
        if (w == 0 && salt == 1) return '1;
        if (w == 1 && salt == 1) return '0;
        return NSLOT'(32'hA5C3 ^ (32'h1357 * (w + 1 + salt * 8)));
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check_eq("R1", int'({drive_low, drive_high}), 0);
        check_eq("R1", int'(irq_vec), 0);
        check_eq("R1", int'(quiet_mode), 0);
        rst_n = 1'b1;
        // R1: first start after the idle gap, continuous mode
        expect_run(GAP, 1'b0, 1'b0, "R1");
        start_width = 3'd0;
        expect_run(start_len(0), 1'b1, 1'b0, "R1");
        run_tail(pattern(0, 0), 1'b0);
        for (int w = 1; w < 8; w++)
            cont_cycle(w, (w == 7), pattern(w, 0));
        for (int w = 0; w < 8; w++)
            quiet_cycle(w, (w != 7), pattern(w, 1));
        cont_cycle(2, 1'b0, pattern(2, 2));
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule